// File: doc/BRIEF.md
# Programmable Systematic Reed-Solomon Encoder

This block encodes a stream of 8-bit symbols with a Reed-Solomon code over GF(2^8). Each codeword starts with a symbol marked by the frame-start input. The information symbols leave the block unchanged, two cycles after they enter. The block then appends the parity symbols, which are the remainder of the message polynomial divided by a programmable monic generator polynomial. One symbol-rate clock drives everything. The input may pause in the middle of a codeword, and codewords may follow one another with no idle cycles other than the parity slots.

Software sets three things through a small register port: the total codeword length, the parity count (0 to 20) and the low-order generator coefficients. The block samples all three when a codeword starts, so a write made in the middle of a codeword only affects the next one. Shortened codes are supported: the number of information symbols is the codeword length minus the parity count.

Top module: `rs_enc_top`

## Requirements
- R1: After reset, `validOut` and `sofOut` are low, and reading any register returns 0.
- R2: Register port map: address 0 holds the codeword length N, address 1 holds the parity count P, and addresses 2+i (i = 0..19) hold generator coefficient g_i, the factor of x^i (the x^P term is an implicit 1). A write takes effect on the clock edge at which `regWr` is sampled. A write of a P value above 20 is ignored. Raising `regRd` updates `regDout` at the next edge. Unmapped addresses read as 0.
- R3: An information symbol that is accepted with `validIn` high appears unchanged on `dataOut`, with `validOut` high, in the cycle two after the one in which it was presented. No output cycle carries `validOut` unless it holds a codeword symbol.
- R4: Directly after the K = N - P information symbols, the block drives P parity symbols on consecutive cycles with `validOut` high. These are the coefficients of (m(x)·x^P) mod g(x), highest degree first. Arithmetic uses the field polynomial x^8+x^4+x^3+x^2+1 (0x11D).
- R5: `sofOut` is high together with the first information symbol of each codeword and low at all other times.
- R6: If `validIn` drops in the middle of the information part, the output shows the same gaps, and the parity is still computed over the accepted symbols only.
- R7: Input symbols presented during the parity output phase, including any frame-start marker, are discarded. They change neither the current parity nor the next codeword.
- R8: With P = 0 the codeword consists of the N information symbols only, with no parity cycles.
- R9: N, P and the coefficients are sampled when a frame-start symbol is accepted. A register write made during a codeword applies from the next codeword.
- R10: A frame-start symbol that arrives during the information phase abandons the codeword in progress without emitting parity, and starts a new codeword with cleared parity state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol-rate clock |
| rstN | input | 1 | Active-low synchronous reset |
| dataIn | input | 8 | Input symbol |
| validIn | input | 1 | Input symbol is valid |
| sofIn | input | 1 | Input symbol is the first of a codeword |
| dataOut | output | 8 | Output symbol (information or parity) |
| validOut | output | 1 | Output symbol is valid |
| sofOut | output | 1 | Output symbol is the first of a codeword |
| regAddr | input | 5 | Register port address |
| regDin | input | 8 | Register write data |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regDout | output | 8 | Register read data, valid the cycle after `regRd` |

## Verification
The assertions assume that the programmed length satisfies N > P, so that every codeword has at least one information symbol. They also assume that `sofIn` is only meaningful together with `validIn`. The stimulus keeps N between 40 and 255 with P no larger than 16, and always raises the frame-start marker together with a valid symbol. Between codewords the bench leaves exactly P cycles of idle time or of discarded junk symbols, which is the shortest spacing the block accepts. It also deliberately injects an abandoned codeword and a mid-codeword register write.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;
  localparam int SYM_W     = 8;
  localparam int MAX_PAR   = 20;
  localparam int ADDR_W    = 5;
  localparam int LEN_W     = SYM_W + 1;
  localparam logic [SYM_W:0] FIELD_POLY = 9'h11D;

  localparam logic [ADDR_W-1:0] ADDR_LEN   = 5'd0;
  localparam logic [ADDR_W-1:0] ADDR_PAR   = 5'd1;
  localparam logic [ADDR_W-1:0] ADDR_COEF0 = 5'd2;

  typedef logic [SYM_W-1:0] sym_t;

  typedef enum logic [1:0] {ST_IDLE, ST_INFO, ST_PARITY} encState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takeInfo;   // load input symbol, advance divider, emit it
    logic clearPar;   // divider starts from zero state this cycle
    logic shiftPar;   // emit top stage, shift toward top
  } ctlStb_t;

  // GF(2^8) product: accumulate a*x^i for each set bit of b
  function automatic sym_t gfMul(sym_t a, sym_t b);
    sym_t acc;
    sym_t term;
    acc  = '0;
    term = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ term;
      term = {term[SYM_W-2:0], 1'b0} ^ (term[SYM_W-1] ? FIELD_POLY[SYM_W-1:0] : '0);
    end
    return acc;
  endfunction
endpackage

// File: rtl/rs_enc_ctrl.sv
module rs_enc_ctrl
  import rs_enc_pkg::*;
#(
  parameter int NPAR = MAX_PAR,
  localparam int PW  = $clog2(NPAR + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         aValid,
  input  logic                         aSof,
  input  logic [ADDR_W-1:0]            regAddr,
  input  sym_t                         regDin,
  input  logic                         regWr,
  input  logic                         regRd,
  output sym_t                         regDout,
  output ctlStb_t                      stb,
  output logic [NPAR-1:0][SYM_W-1:0]   stageCoef
);
  sym_t                       regLen;
  logic [PW-1:0]              regPar;
  logic [NPAR-1:0][SYM_W-1:0] regCoef;
  logic [NPAR-1:0][SYM_W-1:0] alignLive, capAlign;
  logic [LEN_W-1:0]           liveK, capK, effK, cnt, curCnt;
  logic [PW-1:0]              capPar, effPar, parCnt;
  encState_t                  state;
  logic                       takeInfo, lastInfo;
  sym_t                       rdMux;

  // register writes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      regLen  <= '0;
      regPar  <= '0;
      regCoef <= '0;
    end else if (regWr) begin
      if (regAddr == ADDR_LEN) regLen <= regDin;
      else if (regAddr == ADDR_PAR) begin
        if (regDin <= SYM_W'(NPAR)) regPar <= regDin[PW-1:0];
      end else begin
        for (int i = 0; i < NPAR; i++)
          if (regAddr == ADDR_W'(int'(ADDR_COEF0) + i)) regCoef[i] <= regDin;
      end
    end
  end

  // register reads
  always_comb begin
    rdMux = '0;
    if (regAddr == ADDR_LEN) rdMux = regLen;
    else if (regAddr == ADDR_PAR) rdMux = SYM_W'(regPar);
    for (int i = 0; i < NPAR; i++)
      if (regAddr == ADDR_W'(int'(ADDR_COEF0) + i)) rdMux = regCoef[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) regDout <= '0;
    else if (regRd) regDout <= rdMux;
  end

  // coefficient g_i drives divider stage NPAR-P+i; lower stages get zero
  always_comb begin
    alignLive = '0;
    for (int j = 0; j < NPAR; j++)
      for (int i = 0; i < NPAR; i++)
        if (i + NPAR - j == int'(regPar)) alignLive[j] = regCoef[i];
  end

  assign liveK  = LEN_W'(regLen) - LEN_W'(regPar);
  assign effK   = aSof ? liveK : capK;
  assign effPar = aSof ? regPar : capPar;
  assign curCnt = aSof ? '0 : cnt;

  assign takeInfo  = aValid && (state != ST_PARITY) && (aSof || state == ST_INFO);
  assign lastInfo  = takeInfo && (curCnt + LEN_W'(1) == effK);
  assign stb       = '{takeInfo: takeInfo, clearPar: takeInfo && aSof, shiftPar: state == ST_PARITY};
  assign stageCoef = aSof ? alignLive : capAlign;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      parCnt   <= '0;
      capK     <= '0;
      capPar   <= '0;
      capAlign <= '0;
    end else begin
      if (takeInfo) begin
        cnt <= curCnt + LEN_W'(1);
        if (aSof) begin
          capK     <= liveK;
          capPar   <= regPar;
          capAlign <= alignLive;
        end
      end
      if (lastInfo) begin
        state  <= (effPar != '0) ? ST_PARITY : ST_IDLE;
        parCnt <= '0;
      end else if (takeInfo) begin
        state <= ST_INFO;
      end else if (state == ST_PARITY) begin
        parCnt <= parCnt + PW'(1);
        if (parCnt == capPar - PW'(1)) state <= ST_IDLE;
      end
    end
  end

  a_r2_par_bound: assert property (@(posedge clk) disable iff (!rstN)
    (regPar <= PW'(NPAR)) && (capPar <= PW'(NPAR)));

  a_r4_par_count: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PARITY) |-> (parCnt < capPar));

  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_INFO && !(aValid && aSof)) |=> ($stable(capK) && $stable(capPar)));

  a_r10_restart: assert property (@(posedge clk) disable iff (!rstN)
    (aValid && aSof && state != ST_PARITY) |=> (cnt == LEN_W'(1)));
endmodule

// File: rtl/rs_enc_dp.sv
module rs_enc_dp
  import rs_enc_pkg::*;
#(
  parameter int NPAR = MAX_PAR
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  sym_t                       dataIn,
  input  logic                       validIn,
  input  logic                       sofIn,
  output logic                       aValid,
  output logic                       aSof,
  input  ctlStb_t                    stb,
  input  logic [NPAR-1:0][SYM_W-1:0] stageCoef,
  output sym_t                       dataOut,
  output logic                       validOut,
  output logic                       sofOut
);
  sym_t                       aData;
  logic [NPAR-1:0][SYM_W-1:0] par, divNext;
  sym_t                       fb;

  // input stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      aValid <= 1'b0;
      aSof   <= 1'b0;
      aData  <= '0;
    end else begin
      aValid <= validIn;
      aSof   <= validIn && sofIn;
      aData  <= dataIn;
    end
  end

  assign fb = aData ^ (stb.clearPar ? '0 : par[NPAR-1]);

  for (genvar j = 0; j < NPAR; j++) begin : g_stage
    if (j == 0) begin : g_low
      assign divNext[j] = gfMul(fb, stageCoef[j]);
    end else begin : g_up
      assign divNext[j] = (stb.clearPar ? '0 : par[j-1]) ^ gfMul(fb, stageCoef[j]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      par      <= '0;
      dataOut  <= '0;
      validOut <= 1'b0;
      sofOut   <= 1'b0;
    end else begin
      validOut <= stb.takeInfo || stb.shiftPar;
      sofOut   <= stb.clearPar;
      if (stb.takeInfo) begin
        par     <= divNext;
        dataOut <= aData;
      end else if (stb.shiftPar) begin
        par     <= {par[NPAR-2:0], SYM_W'(0)};
        dataOut <= par[NPAR-1];
      end
    end
  end

  a_r3_pass_through: assert property (@(posedge clk) disable iff (!rstN)
    stb.takeInfo |=> (validOut && dataOut == $past(aData)));

  a_r4_parity_out: assert property (@(posedge clk) disable iff (!rstN)
    stb.shiftPar |=> (validOut && !sofOut && dataOut == $past(par[NPAR-1])));

  a_r5_sof_valid: assert property (@(posedge clk) disable iff (!rstN)
    sofOut |-> validOut);
endmodule

// File: rtl/rs_enc_top.sv
module rs_enc_top
  import rs_enc_pkg::*;
#(
  parameter int NPAR = MAX_PAR
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SYM_W-1:0]  dataIn,
  input  logic              validIn,
  input  logic              sofIn,
  output logic [SYM_W-1:0]  dataOut,
  output logic              validOut,
  output logic              sofOut,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [SYM_W-1:0]  regDin,
  input  logic              regWr,
  input  logic              regRd,
  output logic [SYM_W-1:0]  regDout
);
  logic                       aValid, aSof;
  ctlStb_t                    stb;
  logic [NPAR-1:0][SYM_W-1:0] stageCoef;

  rs_enc_ctrl #(.NPAR(NPAR)) ctrl_i (
    .clk(clk), .rstN(rstN), .aValid(aValid), .aSof(aSof),
    .regAddr(regAddr), .regDin(regDin), .regWr(regWr), .regRd(regRd),
    .regDout(regDout), .stb(stb), .stageCoef(stageCoef)
  );

  rs_enc_dp #(.NPAR(NPAR)) dp_i (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .validIn(validIn), .sofIn(sofIn),
    .aValid(aValid), .aSof(aSof), .stb(stb), .stageCoef(stageCoef),
    .dataOut(dataOut), .validOut(validOut), .sofOut(sofOut)
  );
endmodule

// File: tb/rs_enc_top_tb_top.sv
module rs_enc_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] dataIn;
  logic       validIn, sofIn;
  logic [7:0] dataOut;
  logic       validOut, sofOut;
  logic [4:0] regAddr;
  logic [7:0] regDin;
  logic       regWr, regRd;
  logic [7:0] regDout;

  always #10 clk = ~clk;

  rs_enc_top dut_i (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .validIn(validIn), .sofIn(sofIn),
    .dataOut(dataOut), .validOut(validOut), .sofOut(sofOut),
    .regAddr(regAddr), .regDin(regDin), .regWr(regWr), .regRd(regRd), .regDout(regDout)
  );

  int    cyc = 0;
  int    nChecks = 0;
  int    nFails = 0;
  bit    running = 0;
  bit    done = 0;
  int    expD[int];
  bit    expS[int];
  string expTag[int];
  int    shN = 0, shP = 0;
  int    shG[20];

  always @(posedge clk) cyc <= cyc + 1;

  // reference field product, shift-and-reduce form
  function automatic int gm(int a, int b);
    int r = 0;
    for (int i = 0; i < 8; i++) begin
      if (b & 1) r = r ^ a;
      b = b >> 1;
      a = a << 1;
      if (a & 'h100) a = a ^ 'h11d;
    end
    return r;
  endfunction

  // per-cycle output comparison against the expected schedule
  always @(negedge clk) begin
    if (running && !done) begin
      if (expD.exists(cyc)) begin
        nChecks++;
        if (validOut !== 1'b1 || dataOut !== expD[cyc][7:0] || sofOut !== expS[cyc]) begin
          nFails++;
          $display("FAIL %s cycle %0d: actual v=%0b d=%02h s=%0b expected v=1 d=%02h s=%0b",
                   expTag[cyc], cyc, validOut, dataOut, sofOut, expD[cyc][7:0], expS[cyc]);
        end
      end else if (validOut !== 1'b0) begin
        nChecks++;
        nFails++;
        $display("FAIL R3 cycle %0d: actual validOut=%0b expected 0", cyc, validOut);
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic shWrite(input int a, input int d);
    if (a == 0) shN = d;
    else if (a == 1) begin
      if (d <= 20) shP = d;
    end else if (a >= 2 && a < 22) shG[a-2] = d;
  endtask

  task automatic busWrite(input int a, input int d);
    regAddr = a[4:0]; regDin = d[7:0]; regWr = 1'b1;
    step();
    regWr = 1'b0;
    shWrite(a, d);
  endtask

  task automatic busRead(input int a, output int v);
    regAddr = a[4:0]; regRd = 1'b1;
    step();
    regRd = 1'b0;
    v = int'(regDout);
  endtask

  task automatic idle(input int n);
    validIn = 1'b0; sofIn = 1'b0;
    repeat (n) step();
  endtask

  // generator with roots alpha^0..alpha^(p-1); writes P and g_0..g_(p-1)
  task automatic loadGen(input int p);
    int g[21];
    int root = 1;
    for (int i = 0; i < 21; i++) g[i] = 0;
    g[0] = 1;
    for (int i = 0; i < p; i++) begin
      for (int j = i + 1; j > 0; j--) g[j] = g[j-1] ^ gm(g[j], root);
      g[0] = gm(g[0], root);
      root = gm(root, 2);
    end
    busWrite(1, p);
    for (int i = 0; i < p; i++) busWrite(2 + i, g[i]);
  endtask

  // nSend < 0: full codeword; otherwise abandoned after nSend symbols
  task automatic sendFrame(input string tag, input int nSend, input int gapEvery,
                           input bit junk, input int wrAt, input int wrAddr, input int wrData);
    int kk, pp, last, d, fb;
    int gg[20];
    int rem[20];
    bit full;
    kk = shN - shP;
    pp = shP;
    gg = shG;
    for (int i = 0; i < 20; i++) rem[i] = 0;
    if (nSend < 0) nSend = kk;
    full = (nSend == kk);
    last = 0;
    for (int i = 0; i < nSend; i++) begin
      if (gapEvery > 0 && i > 0 && (i % gapEvery) == 0) begin
        validIn = 1'b0; sofIn = 1'b0;
        step();
      end
      d = $urandom_range(0, 255);
      dataIn = d[7:0]; validIn = 1'b1; sofIn = (i == 0);
      if (i == wrAt) begin
        regAddr = wrAddr[4:0]; regDin = wrData[7:0]; regWr = 1'b1;
      end
      expD[cyc+2] = d; expS[cyc+2] = (i == 0); expTag[cyc+2] = tag;
      if (pp > 0) begin
        fb = d ^ rem[pp-1];
        for (int j = pp - 1; j > 0; j--) rem[j] = rem[j-1] ^ gm(fb, gg[j]);
        rem[0] = gm(fb, gg[0]);
      end
      last = cyc;
      step();
      if (i == wrAt) begin
        regWr = 1'b0;
        shWrite(wrAddr, wrData);
      end
    end
    validIn = 1'b0; sofIn = 1'b0;
    if (full) begin
      for (int j = 0; j < pp; j++) begin
        expD[last+3+j] = rem[pp-1-j]; expS[last+3+j] = 1'b0; expTag[last+3+j] = tag;
      end
      for (int j = 0; j < pp; j++) begin
        if (junk) begin
          // R7: symbols and a frame marker offered during the parity phase
          dataIn = 8'($urandom_range(0, 255)); validIn = 1'b1; sofIn = (j == 0);
        end
        step();
      end
      validIn = 1'b0; sofIn = 1'b0;
    end
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL R3 watchdog: actual run still busy, expected completion");
    finishRun();
  end

  initial begin
    int v;
    for (int i = 0; i < 20; i++) shG[i] = 0;
    rstN = 1'b0; dataIn = '0; validIn = 1'b0; sofIn = 1'b0;
    regAddr = '0; regDin = '0; regWr = 1'b0; regRd = 1'b0;
    repeat (3) step();
    check("R1 validOut in reset", int'(validOut), 0);
    check("R1 sofOut in reset", int'(sofOut), 0);
    rstN = 1'b1;
    step();
    running = 1'b1;
    busRead(0, v); check("R1 length reg after reset", v, 0);
    busRead(1, v); check("R1 parity reg after reset", v, 0);

    // R2: register map and read-back
    busWrite(0, 60);
    loadGen(16);
    busRead(0, v); check("R2 length readback", v, 60);
    busRead(1, v); check("R2 parity readback", v, 16);
    busRead(7, v); check("R2 coef g5 readback", v, shG[5]);
    busWrite(1, 25);
    busRead(1, v); check("R2 oversize parity ignored", v, 16);
    busRead(30, v); check("R2 unmapped reads zero", v, 0);
    idle(2);

    // R3 R4 R5: continuous codeword
    sendFrame("R4", -1, 0, 1'b0, -1, 0, 0);
    idle(3);
    // R6: bursty input
    sendFrame("R6", -1, 3, 1'b0, -1, 0, 0);
    idle(2);
    // R7: junk during parity, next codeword back-to-back
    sendFrame("R7", -1, 0, 1'b1, -1, 0, 0);
    sendFrame("R7", -1, 0, 1'b0, -1, 0, 0);
    idle(2);
    // R9: length written mid-codeword applies to the next one
    sendFrame("R9", -1, 0, 1'b0, 4, 0, 50);
    sendFrame("R9", -1, 0, 1'b0, -1, 0, 0);
    idle(2);
    // R10: abandoned codeword followed immediately by a new one
    sendFrame("R10", 10, 0, 1'b0, -1, 0, 0);
    sendFrame("R10", -1, 2, 1'b0, -1, 0, 0);
    idle(2);
    // R8: no parity
    busWrite(1, 0);
    busWrite(0, 40);
    sendFrame("R8", -1, 0, 1'b0, -1, 0, 0);
    sendFrame("R8", -1, 0, 1'b0, -1, 0, 0);
    idle(2);
    // R4 R5: longest codeword with eight parity symbols
    loadGen(8);
    busWrite(0, 255);
    sendFrame("R5", -1, 5, 1'b0, -1, 0, 0);
    idle(10);
    finishRun();
  end
endmodule